// File: doc/BRIEF.md
# Byte-Wide EEPROM Access and Boot Loader Controller

This controller sits between a host register interface and an external byte-wide EEPROM. The EEPROM is seen through a simple request/acknowledge byte port. The host loads an address and a data byte, then sets a self-clearing control bit. That bit fetches one byte into the data register, or stores the data byte into the EEPROM.

A third control bit starts a burst load. The controller walks the EEPROM as a chain of records and turns every payload byte into a one-cycle write on an on-chip memory port. The 24-bit destination of each write joins a 9-bit host-programmed base with a 15-bit offset taken from the record.

The EEPROM position at which a burst begins is not set by the host. A burst that is the first EEPROM operation after reset starts at address 0. Any later burst starts just after the last byte that was accessed, whether that access was a single transfer or part of a burst. Firmware can therefore place a single-byte header in front of a record chain and then resume from it.

Top module: `eeb_ctrl`

## Requirements
- R1: After synchronous reset, all four host registers read 0, `ee_req` is 0 and `mem_we` is 0.
- R2: Host registers are chosen by a 2-bit select: 0 = EEPROM address (16 bits), 1 = data byte, 2 = control, 3 = destination base (9 bits). The address, data and base registers read back what was written. Control bits are: bit 0 = single write, bit 1 = single read, bit 2 = burst start, bit 3 = busy (read-only).
- R3: Setting control bit 1 reads the EEPROM byte at the address register into the data register. Bit 1 reads 1 while the read is pending and 0 once the data register holds the byte.
- R4: Setting control bit 0 issues one EEPROM access with `ee_we` = 1, carrying the address register and the data byte. Bit 0 reads 1 while the write is pending and clears by itself.
- R5: Once raised, `ee_req`, `ee_we` and `ee_addr` hold steady until `ee_ack` arrives. The acknowledge latency may be any number of cycles.
- R6: Setting control bit 2 starts a burst. Bit 2 reads 1 during the burst and clears by itself. Busy (bit 3) reads 1 exactly while any operation is active.
- R7: A burst that is the first EEPROM operation after reset begins at EEPROM address 0. Any other burst begins at the address after the most recent EEPROM access.
- R8: A burst record is, in order, the offset low byte, the offset high byte, a length N, and then N payload bytes. The payload bytes are written to consecutive destinations, with the offset wrapping within its low 15 bits. A record with N = 0 ends the burst.
- R9: The destination address is {base[8:0], offset[14:0]}. Bit 15 of the record offset is ignored.
- R10: A control write made while busy is ignored. No extra EEPROM access results, and the data register is unchanged.
- R11: If one control write sets several request bits, burst is taken over read, and read over write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select for the write |
| host_wdata | input | 16 | Host write data |
| host_rsel | input | 2 | Register select for readback |
| host_rdata | output | 16 | Readback of the selected register |
| ee_req | output | 1 | EEPROM access request, held until acknowledge |
| ee_we | output | 1 | Access is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle acknowledge |
| ee_rdata | input | 8 | Read byte, valid with acknowledge |
| mem_we | output | 1 | On-chip memory write pulse |
| mem_addr | output | 24 | Memory destination address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The bench drives several burst patterns against a modelled EEPROM whose acknowledge latency cycles through 0 to 3:
- A first burst after reset with an offset whose bit 15 is set, followed by a record that wraps at the 15-bit boundary. This separates a start at address 0 from a start anywhere else, and shows whether the offset MSB is dropped or the offset carries into the base.
- Bursts that follow a single read, a single write and a previous burst. These tell continuation from the last access apart from continuation from the last burst only.
- A sweep of single reads at addresses with high bits set, checked against the model.
- Multi-bit control writes, which tell the priority order apart.
- A control write made during a burst, which shows whether busy gating holds.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ONE, ST_OFF_LO, ST_OFF_HI, ST_LEN, ST_DATA
    } eeb_state_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_CTRL = 2'd2, SEL_BASE = 2'd3
    } eeb_sel_e;

    localparam int CB_WR    = 0;
    localparam int CB_RD    = 1;
    localparam int CB_BURST = 2;

    typedef struct packed {
        logic burst;
        logic rd;
        logic wr;
    } eeb_launch_t;

    // burst beats read, read beats write
    function automatic eeb_launch_t eeb_pick(input logic [2:0] bits);
        eeb_launch_t r;
        r = '0;
        if (bits[CB_BURST])   r.burst = 1'b1;
        else if (bits[CB_RD]) r.rd    = 1'b1;
        else if (bits[CB_WR]) r.wr    = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/eeb_regs.sv
module eeb_regs
    import eeb_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int HOST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DW-1:0]     rd_byte,
    output logic [EE_AW-1:0]  addr_q,
    output logic [DW-1:0]     data_q,
    output logic [BASE_W-1:0] base_q,
    output eeb_launch_t       launch
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
        end else begin
            if (host_we) begin
                case (host_sel)
                    SEL_ADDR: addr_q <= host_wdata[EE_AW-1:0];
                    SEL_DATA: data_q <= host_wdata[DW-1:0];
                    SEL_BASE: base_q <= host_wdata[BASE_W-1:0];
                    default:  ;
                endcase
            end
            if (rd_done) data_q <= rd_byte;
        end
    end

    always_comb begin
        launch = '0;
        if (host_we && host_sel == SEL_CTRL && !busy)
            launch = eeb_pick(host_wdata[2:0]);
    end

    assert_data_capture_R3: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> data_q == $past(rd_byte));
endmodule

// File: rtl/eeb_seq.sv
module eeb_seq
    import eeb_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int LOW_W  = 15,
    parameter int BASE_W = 9,
    localparam int MA_W  = BASE_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  eeb_launch_t       launch,
    input  logic [EE_AW-1:0]  host_addr,
    input  logic [DW-1:0]     host_data,
    input  logic [BASE_W-1:0] base,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              mem_we,
    output logic [MA_W-1:0]   mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              rd_done,
    output logic              busy,
    output logic [2:0]        pend
);
    eeb_state_e       state;
    logic [EE_AW-1:0] cur_ee, next_ee;
    logic             op_we;
    logic [DW-1:0]    off_lo, wbyte, cnt;
    logic [LOW_W-1:0] dst;
    logic [2*DW-1:0]  off_full;

    assign off_full = {ee_rdata, off_lo};
    assign ee_req   = state != ST_IDLE;
    assign ee_we    = state == ST_ONE && op_we;
    assign ee_addr  = cur_ee;
    assign ee_wdata = wbyte;
    assign busy     = state != ST_IDLE;
    assign rd_done  = ee_ack && state == ST_ONE && !op_we;
    assign pend[CB_WR]    = state == ST_ONE && op_we;
    assign pend[CB_RD]    = state == ST_ONE && !op_we;
    assign pend[CB_BURST] = state inside {ST_OFF_LO, ST_OFF_HI, ST_LEN, ST_DATA};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_ee    <= '0;
            next_ee   <= '0;
            op_we     <= 1'b0;
            off_lo    <= '0;
            wbyte     <= '0;
            cnt       <= '0;
            dst       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (state == ST_IDLE) begin
                if (launch.burst) begin
                    cur_ee <= next_ee;
                    state  <= ST_OFF_LO;
                end else if (launch.rd || launch.wr) begin
                    cur_ee <= host_addr;
                    op_we  <= launch.wr;
                    wbyte  <= host_data;
                    state  <= ST_ONE;
                end
            end else if (ee_ack) begin
                cur_ee  <= cur_ee + EE_AW'(1);
                next_ee <= cur_ee + EE_AW'(1);
                case (state)
                    ST_ONE:    state <= ST_IDLE;
                    ST_OFF_LO: begin
                        off_lo <= ee_rdata;
                        state  <= ST_OFF_HI;
                    end
                    ST_OFF_HI: begin
                        dst   <= off_full[LOW_W-1:0];
                        state <= ST_LEN;
                    end
                    ST_LEN: begin
                        cnt   <= ee_rdata;
                        state <= (ee_rdata == '0) ? ST_IDLE : ST_DATA;
                    end
                    ST_DATA: begin
                        mem_we    <= 1'b1;
                        mem_addr  <= {base, dst};
                        mem_wdata <= ee_rdata;
                        dst       <= dst + LOW_W'(1);
                        cnt       <= cnt - DW'(1);
                        if (cnt == DW'(1)) state <= ST_OFF_LO;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we));
    assert_ptr_next_R7: assert property (@(posedge clk) disable iff (rst)
        ee_req && ee_ack |=> next_ee == $past(ee_addr) + EE_AW'(1));
    assert_mem_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(ee_ack));
    assert_dest_base_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[MA_W-1:LOW_W] == $past(base));
    assert_launch_idle_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(launch.burst || launch.rd || launch.wr));
endmodule

// File: rtl/eeb_ctrl.sv
module eeb_ctrl
    import eeb_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int LOW_W  = 15,
    parameter int BASE_W = 9,
    parameter int HOST_W = 16,
    localparam int MA_W  = BASE_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [1:0]        host_rsel,
    output logic [HOST_W-1:0] host_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              mem_we,
    output logic [MA_W-1:0]   mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    logic [EE_AW-1:0]  addr_q;
    logic [DW-1:0]     data_q;
    logic [BASE_W-1:0] base_q;
    eeb_launch_t       launch;
    logic              busy, rd_done;
    logic [2:0]        pend;

    eeb_regs #(.EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .HOST_W(HOST_W)) regs_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .busy(busy), .rd_done(rd_done), .rd_byte(ee_rdata),
        .addr_q(addr_q), .data_q(data_q), .base_q(base_q), .launch(launch));

    eeb_seq #(.EE_AW(EE_AW), .DW(DW), .LOW_W(LOW_W), .BASE_W(BASE_W)) seq_i (
        .clk(clk), .rst(rst), .launch(launch), .host_addr(addr_q), .host_data(data_q),
        .base(base_q), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
        .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_done(rd_done), .busy(busy),
        .pend(pend));

    always_comb begin
        case (host_rsel)
            SEL_ADDR: host_rdata = HOST_W'(addr_q);
            SEL_DATA: host_rdata = HOST_W'(data_q);
            SEL_CTRL: host_rdata = HOST_W'({busy, pend});
            default:  host_rdata = HOST_W'(base_q);
        endcase
    end
endmodule

// File: tb/eeb_ctrl_tb_top.sv
module eeb_ctrl_tb_top;
    logic clk = 1'b0, rst = 1'b1;
    logic host_we = 1'b0;
    logic [1:0] host_sel = 2'd0, host_rsel = 2'd0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic ee_req, ee_we, ee_ack = 1'b0;
    logic [15:0] ee_addr;
    logic [7:0] ee_wdata, ee_rdata = '0, mem_wdata;
    logic mem_we;
    logic [23:0] mem_addr;

    always #2.5 clk = ~clk;

    eeb_ctrl dut_i (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0]  rom [0:1023];
    logic [15:0] tr_addr [0:255];
    logic        tr_we [0:255];
    int tr_n = 0;
    logic [23:0] cap_addr [0:63];
    logic [7:0]  cap_data [0:63];
    int cap_n = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // EEPROM model: latency cycles 0..3 by transaction count
    initial forever begin
        @(negedge clk);
        if (!rst && ee_req) begin
            repeat (tr_n % 4) @(negedge clk);
            tr_addr[tr_n[7:0]] = ee_addr;
            tr_we[tr_n[7:0]] = ee_we;
            tr_n++;
            if (ee_we) rom[ee_addr[9:0]] = ee_wdata;
            ee_rdata = rom[ee_addr[9:0]];
            ee_ack = 1'b1;
            @(negedge clk);
            ee_ack = 1'b0;
        end
    end

    always @(negedge clk) if (!rst && mem_we) begin
        cap_addr[cap_n[5:0]] = mem_addr;
        cap_data[cap_n[5:0]] = mem_wdata;
        cap_n++;
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] sel, output logic [15:0] val);
        host_rsel = sel;
        #0.5;
        val = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        rdreg(2'd2, v);
        while (v[3]) begin
            @(negedge clk);
            rdreg(2'd2, v);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int base_tr, base_cap;
        for (int i = 0; i < 1024; i++) rom[i] = 8'(i * 5 + 1);
        // burst chain at 0: offset 0x8123 len 3, offset 0x7FFE len 3, end
        rom[0]=8'h23; rom[1]=8'h81; rom[2]=8'h03; rom[3]=8'hA0; rom[4]=8'hA1; rom[5]=8'hA2;
        rom[6]=8'hFE; rom[7]=8'h7F; rom[8]=8'h03; rom[9]=8'hB0; rom[10]=8'hB1; rom[11]=8'hB2;
        rom[12]=8'h00; rom[13]=8'h00; rom[14]=8'h00;
        rom[15]=8'h10; rom[16]=8'h00; rom[17]=8'h01; rom[18]=8'h5A;
        rom[19]=8'h00; rom[20]=8'h00; rom[21]=8'h00;
        for (int i = 0; i < 3; i++) begin
            rom[16'h106 + i] = 8'h00; rom[16'h201 + i] = 8'h00; rom[16'h301 + i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rdreg(2'(s), v);
            check($sformatf("R1 reg %0d after reset", s), v, 16'h0);
        end
        check("R1 ee_req idle", ee_req, 1'b0);
        check("R1 mem_we idle", mem_we, 1'b0);
        // R2 register readback sweep
        foreach (v[b]) begin
            wr(2'd0, 16'h1 << b); rdreg(2'd0, v);
            check("R2 address register", v, 16'h1 << b);
        end
        wr(2'd1, 16'h77); rdreg(2'd1, v); check("R2 data register", v, 16'h77);
        wr(2'd3, 16'h1A5); rdreg(2'd3, v); check("R2 base register", v, 16'h1A5);
        // R6/R7/R8/R9 first burst after reset begins at 0
        wr(2'd2, 16'h4);
        rdreg(2'd2, v); check("R6 burst pending and busy", v[3:0], 4'hC);
        wr(2'd2, 16'h2);   // R10 read request while busy
        wait_idle();
        rdreg(2'd2, v); check("R6 burst bit self-clears", v[3:0], 4'h0);
        check("R10 no extra access during burst", tr_n, 15);
        rdreg(2'd1, v); check("R10 data register untouched", v, 16'h77);
        for (int i = 0; i < 15; i++) begin
            check("R7 first burst address from 0", tr_addr[i], 16'(i));
            check("R8 burst accesses are reads", tr_we[i], 1'b0);
        end
        check("R8 payload write count", cap_n, 6);
        for (int i = 0; i < 6; i++) begin
            int off;
            off = (i < 3) ? ((16'h8123 + i) & 16'h7FFF) : ((16'h7FFE + i - 3) & 16'h7FFF);
            check("R9 destination address", cap_addr[i], (24'h1A5 << 15) | 24'(off));
            check("R8 payload byte", cap_data[i], (i < 3) ? 8'hA0 + 8'(i) : 8'hB0 + 8'(i - 3));
        end
        // R7 continuation after a burst
        wr(2'd2, 16'h4); wait_idle();
        check("R7 second burst starts after first", tr_addr[15], 16'd15);
        check("R8 second burst writes", cap_n, 7);
        check("R9 second burst address", cap_addr[6], (24'h1A5 << 15) | 24'h10);
        check("R8 second burst byte", cap_data[6], 8'h5A);
        // R3 read sweep with high address bits
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a;
            a = 16'(k * 16'h2C47 + 16'h0011);
            base_tr = tr_n;
            wr(2'd0, a); wr(2'd2, 16'h2);
            rdreg(2'd2, v); check("R3 read pending", v[3:0], 4'hA);
            wait_idle();
            rdreg(2'd1, v); check("R3 read data", v, 16'(rom[a[9:0]]));
            check("R5 read address", tr_addr[base_tr], a);
            check("R3 single access", tr_n - base_tr, 1);
        end
        // R7 burst after single read at 0x105
        wr(2'd0, 16'h0105); wr(2'd2, 16'h2); wait_idle();
        base_tr = tr_n; base_cap = cap_n;
        wr(2'd2, 16'h4); wait_idle();
        check("R7 burst resumes after read", tr_addr[base_tr], 16'h0106);
        check("R8 empty record writes nothing", cap_n, base_cap);
        // R4 single write
        wr(2'd0, 16'h0200); wr(2'd1, 16'h3C); wr(2'd2, 16'h1);
        rdreg(2'd2, v); check("R4 write pending", v[3:0], 4'h9);
        wait_idle();
        check("R4 write strobe", tr_we[tr_n - 1], 1'b1);
        check("R4 write address", tr_addr[tr_n - 1], 16'h0200);
        check("R4 written byte", rom[10'h200], 8'h3C);
        rdreg(2'd2, v); check("R4 write bit clears", v[3:0], 4'h0);
        base_tr = tr_n;
        wr(2'd2, 16'h4); wait_idle();
        check("R7 burst resumes after write", tr_addr[base_tr], 16'h0201);
        // R11 priority
        wr(2'd0, 16'h0300); wr(2'd1, 16'h99);
        base_tr = tr_n;
        wr(2'd2, 16'h3); wait_idle();
        check("R11 read beats write", tr_we[base_tr], 1'b0);
        rdreg(2'd1, v); check("R11 read data taken", v, 16'(rom[10'h300]));
        base_tr = tr_n;
        wr(2'd2, 16'h7); wait_idle();
        check("R11 burst beats read", tr_addr[base_tr], 16'h0301);
        check("R11 burst length", tr_n - base_tr, 3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule